// File: doc/BRIEF.md
# Frequency Offset Lock Detector

This block decides whether a recovered serial line clock runs close enough to a local reference clock to call the loop frequency-locked. The recovered clock is divided by a fixed ratio, 20 by default, in its own domain. The divided ticks drive a free-running Gray-coded count. The reference domain samples that count at the edges of back-to-back measurement windows of 1024 reference cycles. At each window edge the number of divided periods in the window is compared against the window length. If the two differ by fewer than 16 counts, about 1.6 %, the registered `freq_ok` flag goes high. Otherwise it goes low. The compare never stops, so a lock that drifts away is withdrawn at a later window edge.

An active-low override input, `force_ref_n`, makes the loop track the reference clock. While the override is asserted, `freq_ok` is held low and `track_ref` is high. When the override is released, `track_ref` falls and the loop follows the incoming data. A settle interval of 532 reference cycles (about 10 µs at 53.125 MHz) must then pass. Only after that does the first measurement window open.

The control is a three-state machine:
- **FORCED**: the reset state; the override is in effect.
- **SETTLE**: the settle interval is being timed.
- **MEASURE**: measurement windows are running.

It has these transitions:
- **release**: FORCED to SETTLE, when the override is seen inactive.
- **settle-expiry**: SETTLE to MEASURE, after 532 cycles.
- **override**: SETTLE or MEASURE back to FORCED.
- **window-wrap**: MEASURE to MEASURE at each window edge, where the result is loaded.

Top module: `freq_lock_detector`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it falls, `freq_ok` is 0 and `track_ref` is 1.
- R2: The override passes through a two-flop synchronizer. From the third rising reference edge after `force_ref_n` is driven low, and for as long as it stays low, `track_ref` is 1 and `freq_ok` is 0.
- R3: `track_ref` falls on the third rising reference edge after `force_ref_n` is driven high. This starts the settle interval.
- R4: `freq_ok` stays 0 during the settle interval and the first window. The first result is loaded exactly 1556 reference edges (532 settle plus 1024 window) after the edge on which `track_ref` fell.
- R5: While measuring, windows follow one another with no gap, each exactly 1024 reference cycles long. Outside an override, `freq_ok` changes only on a window-closing edge.
- R6: At a window-closing edge, `freq_ok` becomes 1 when N, the number of recovered-clock-divided-by-20 periods in the window, satisfies |N − 1024| < 16. Otherwise it becomes 0.
- R7: After `freq_ok` has been set, an offset that grows to 16 counts or more clears it at a later window edge, with no reset or override needed.
- R8: When the synchronized override and a window-closing edge fall on the same cycle, the override wins. `freq_ok` goes to 0 and no result is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock (53.125 MHz nominal) |
| rec_clk | input | 1 | Recovered line clock (20 × reference nominal) |
| rst | input | 1 | Synchronous active-high reset, reference domain |
| force_ref_n | input | 1 | Active-low override: track the reference and hold the flag low |
| freq_ok | output | 1 | Registered frequency-lock flag |
| track_ref | output | 1 | 1 = loop tracks the reference, 0 = loop tracks the incoming data |

## Verification
The override and the window result can land on the same reference edge. At that edge the machine must choose between loading an in-tolerance result and dropping to FORCED. The bench waits until the recovered clock is in tolerance and `freq_ok` is high. It then drives `force_ref_n` low exactly three cycles before a window closes, so the synchronized override arrives on the closing edge. `freq_ok` must still read 1 after the second edge and 0 after the third. If it stayed high, the result would have beaten the override.

// File: rtl/fld_pkg.sv
package fld_pkg;

    typedef enum logic [1:0] {
        ST_FORCED  = 2'd0,
        ST_SETTLE  = 2'd1,
        ST_MEASURE = 2'd2
    } fld_state_e;

endpackage

// File: rtl/fld_rec_counter.sv
module fld_rec_counter #(
    parameter int DIV_RATIO = 20,
    parameter int CW        = 12
) (
    input  logic          rec_clk,
    input  logic          rst_req,
    output logic [CW-1:0] gray_o
);
    localparam int DW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV_RATIO - 1);

    logic          rs1_q, rs2_q;
    logic [DW-1:0] div_q;
    logic [CW-1:0] bin_q;
    logic [CW-1:0] bin_nx;

    // reset is carried into the recovered domain by two flops
    always_ff @(posedge rec_clk) begin
        rs1_q <= rst_req;
        rs2_q <= rs1_q;
    end

    assign bin_nx = bin_q + CW'(1);

    // divide-by-ratio prescaler feeding a running Gray-coded tick count
    always_ff @(posedge rec_clk) begin
        if (rs2_q) begin
            div_q  <= '0;
            bin_q  <= '0;
            gray_o <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q  <= '0;
            bin_q  <= bin_nx;
            gray_o <= bin_nx ^ (bin_nx >> 1);
        end else begin
            div_q  <= div_q + DW'(1);
        end
    end
endmodule

// File: rtl/fld_gray_sync.sv
module fld_gray_sync #(
    parameter int CW = 12
) (
    input  logic          ref_clk,
    input  logic          rst,
    input  logic [CW-1:0] gray_i,
    output logic [CW-1:0] bin_o
);
    logic [CW-1:0] g1_q, g2_q;

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            g1_q <= '0;
            g2_q <= '0;
        end else begin
            g1_q <= gray_i;
            g2_q <= g1_q;
        end
    end

    assign bin_o[CW-1] = g2_q[CW-1];
    for (genvar i = CW - 2; i >= 0; i--) begin : g_dec
        assign bin_o[i] = bin_o[i+1] ^ g2_q[i];
    end
endmodule

// File: rtl/fld_eval.sv
module fld_eval #(
    parameter int CW         = 12,
    parameter int WIN_CYCLES = 1024,
    parameter int TOL_COUNTS = 16
) (
    input  logic [CW-1:0] cur_i,
    input  logic [CW-1:0] base_i,
    output logic          in_tol_o
);
    localparam logic [CW-1:0] WIN_C = CW'(WIN_CYCLES);
    localparam logic [CW-1:0] TOL_C = CW'(TOL_COUNTS);

    logic [CW-1:0] span;
    logic [CW-1:0] dev;

    always_comb begin
        span     = cur_i - base_i;
        dev      = (span >= WIN_C) ? (span - WIN_C) : (WIN_C - span);
        in_tol_o = (dev < TOL_C);
    end
endmodule

// File: rtl/freq_lock_detector.sv
module freq_lock_detector
    import fld_pkg::*;
#(
    parameter int DIV_RATIO     = 20,
    parameter int WIN_CYCLES    = 1024,
    parameter int TOL_COUNTS    = 16,
    parameter int SETTLE_CYCLES = 532
) (
    input  logic ref_clk,
    input  logic rec_clk,
    input  logic rst,
    input  logic force_ref_n,
    output logic freq_ok,
    output logic track_ref
);
    localparam int CW   = $clog2(WIN_CYCLES) + 2;
    localparam int TMAX = (SETTLE_CYCLES > WIN_CYCLES) ? SETTLE_CYCLES : WIN_CYCLES;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] WIN_LAST = TW'(WIN_CYCLES - 1);
    localparam logic [TW-1:0] SET_LAST = TW'(SETTLE_CYCLES - 1);

    logic          fr_s1, fr_s2;
    logic          override;
    fld_state_e    state_q, st_nx;
    logic [TW-1:0] cnt_q;
    logic [CW-1:0] rec_gray;
    logic [CW-1:0] cur_bin;
    logic [CW-1:0] base_q;
    logic          in_tol;
    logic          win_last;
    logic          settle_last;

    fld_rec_counter #(.DIV_RATIO(DIV_RATIO), .CW(CW)) u_rec (
        .rec_clk (rec_clk),
        .rst_req (rst),
        .gray_o  (rec_gray)
    );

    fld_gray_sync #(.CW(CW)) u_sync (
        .ref_clk (ref_clk),
        .rst     (rst),
        .gray_i  (rec_gray),
        .bin_o   (cur_bin)
    );

    fld_eval #(.CW(CW), .WIN_CYCLES(WIN_CYCLES), .TOL_COUNTS(TOL_COUNTS)) u_eval (
        .cur_i    (cur_bin),
        .base_i   (base_q),
        .in_tol_o (in_tol)
    );

    // two-flop synchronizer for the asynchronous override pin
    always_ff @(posedge ref_clk) begin
        if (rst) begin
            fr_s1 <= 1'b0;
            fr_s2 <= 1'b0;
        end else begin
            fr_s1 <= force_ref_n;
            fr_s2 <= fr_s1;
        end
    end

    assign override    = ~fr_s2;
    assign win_last    = (state_q == ST_MEASURE) && (cnt_q == WIN_LAST);
    assign settle_last = (state_q == ST_SETTLE) && (cnt_q == SET_LAST);

    // state register
    always_ff @(posedge ref_clk) begin
        if (rst) state_q <= ST_FORCED;
        else     state_q <= st_nx;
    end

    // next-state logic: override has priority everywhere
    always_comb begin
        st_nx = state_q;
        unique case (state_q)
            ST_FORCED:  if (!override)       st_nx = ST_SETTLE;
            ST_SETTLE:  if (override)        st_nx = ST_FORCED;
                        else if (settle_last) st_nx = ST_MEASURE;
            ST_MEASURE: if (override)        st_nx = ST_FORCED;
            default:                         st_nx = ST_FORCED;
        endcase
    end

    // shared interval counter and window baseline
    always_ff @(posedge ref_clk) begin
        if (rst) begin
            cnt_q  <= '0;
            base_q <= '0;
        end else begin
            if (st_nx != state_q || st_nx == ST_FORCED || win_last)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + TW'(1);
            if (st_nx == ST_MEASURE && (state_q != ST_MEASURE || win_last))
                base_q <= cur_bin;
        end
    end

    // registered outputs
    always_ff @(posedge ref_clk) begin
        if (rst) begin
            freq_ok   <= 1'b0;
            track_ref <= 1'b1;
        end else begin
            track_ref <= (st_nx == ST_FORCED);
            if (st_nx != ST_MEASURE)
                freq_ok <= 1'b0;
            else if (win_last)
                freq_ok <= in_tol;
        end
    end
endmodule

// File: rtl/fld_chk.sv
module fld_chk
    import fld_pkg::*;
#(
    parameter int WIN_CYCLES    = 1024,
    parameter int SETTLE_CYCLES = 532
) (
    input logic       ref_clk,
    input logic       rst,
    input logic       force_s,
    input fld_state_e state,
    input logic [$clog2(((SETTLE_CYCLES > WIN_CYCLES) ? SETTLE_CYCLES : WIN_CYCLES) + 1)-1:0] cnt,
    input logic       win_last,
    input logic       freq_ok,
    input logic       track_ref
);
    // R2
    force_hold_chk: assert property (@(posedge ref_clk) disable iff (rst)
        !force_s |=> (track_ref && !freq_ok));

    // R3
    mode_excl_chk: assert property (@(posedge ref_clk) disable iff (rst)
        freq_ok |-> !track_ref);

    // R4
    settle_low_chk: assert property (@(posedge ref_clk) disable iff (rst)
        (state == ST_SETTLE) |-> !freq_ok);

    // R5
    lock_steady_chk: assert property (@(posedge ref_clk) disable iff (rst)
        (state == ST_MEASURE && force_s && !win_last) |=> $stable(freq_ok));

    // R5
    rise_at_edge_chk: assert property (@(posedge ref_clk) disable iff (rst)
        $rose(freq_ok) |-> $past(win_last));

    // R5
    cnt_range_chk: assert property (@(posedge ref_clk) disable iff (rst)
        (state == ST_MEASURE) |-> (int'(cnt) < WIN_CYCLES));
endmodule

bind freq_lock_detector fld_chk #(
    .WIN_CYCLES    (WIN_CYCLES),
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .ref_clk   (ref_clk),
    .rst       (rst),
    .force_s   (fr_s2),
    .state     (state_q),
    .cnt       (cnt_q),
    .win_last  (win_last),
    .freq_ok   (freq_ok),
    .track_ref (track_ref)
);

// File: tb/freq_lock_detector_test.sv
`timescale 1ns/1ps
module freq_lock_detector_test;
    localparam int WIN    = 1024;
    localparam int SETTLE = 532;
    localparam int TOL    = 16;

    logic ref_clk = 1'b0;
    logic rec_clk = 1'b0;
    logic rst = 1'b1;
    logic force_ref_n = 1'b0;
    wire  freq_ok;
    wire  track_ref;

    int hp_ps = 250;      // recovered half period in ps
    int errors = 0;
    int checks = 0;

    // behavioural model state
    int    m_s1, m_s2, m_st, m_nst, m_cnt, m_dirty;
    bit    m_lock, m_known, m_trk, m_valid, m_ovr, m_wend;
    string m_tag = "R1";

    freq_lock_detector #(
        .DIV_RATIO(20), .WIN_CYCLES(WIN), .TOL_COUNTS(TOL), .SETTLE_CYCLES(SETTLE)
    ) uut (
        .ref_clk(ref_clk), .rec_clk(rec_clk), .rst(rst),
        .force_ref_n(force_ref_n), .freq_ok(freq_ok), .track_ref(track_ref)
    );

    always #5 ref_clk = ~ref_clk;
    initial forever begin
        #(real'(hp_ps) / 1000.0);
        rec_clk = ~rec_clk;
    end

    function automatic bit tol_ok(int hp);
        real c, d;
        c = 10240000.0 / (40.0 * real'(hp));
        d = (c > 1024.0) ? c - 1024.0 : 1024.0 - c;
        return d < real'(TOL);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic set_period(int hp);
        hp_ps   = hp;
        m_dirty = 2;
    endtask

    // reference model, advanced on every reference edge
    always @(posedge ref_clk) begin
        m_valid = 1'b1;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_st = 0; m_cnt = 0;
            m_lock = 0; m_known = 1; m_trk = 1; m_tag = "R1";
        end else begin
            m_ovr  = (m_s2 == 0);
            m_nst  = m_st;
            m_wend = 1'b0;
            case (m_st)
                0: if (!m_ovr) begin m_nst = 1; m_cnt = 0; end
                1: if (m_ovr) m_nst = 0;
                   else if (m_cnt == SETTLE - 1) begin m_nst = 2; m_cnt = 0; end
                   else m_cnt++;
                default: if (m_ovr) m_nst = 0;
                   else if (m_cnt == WIN - 1) begin m_wend = 1'b1; m_cnt = 0; end
                   else m_cnt++;
            endcase
            if (m_nst != 2) begin
                m_lock = 0; m_known = 1;
                m_tag = (m_nst == 0) ? "R2" : "R4";
            end else if (m_wend) begin
                if (m_dirty == 0) begin m_lock = tol_ok(hp_ps); m_known = 1; end
                else m_known = 0;
                if (m_dirty > 0) m_dirty--;
                m_tag = "R6";
            end else begin
                m_tag = "R5";
            end
            m_trk = (m_nst == 0);
            m_st  = m_nst;
            m_s2  = m_s1;
            m_s1  = force_ref_n;
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge ref_clk) begin
        if (m_valid) begin
            chk(m_trk ? "R2" : "R3", "track_ref", int'(track_ref), int'(m_trk));
            if (m_known) chk(m_tag, "freq_ok", int'(freq_ok), int'(m_lock));
        end
    end

    task automatic wait_windows(int n);
        repeat (n * WIN) @(negedge ref_clk);
    endtask

    task automatic release_and_lock();
        @(negedge ref_clk) force_ref_n = 1'b1;
        while (track_ref) @(negedge ref_clk);
        repeat (SETTLE + WIN - 1) @(negedge ref_clk);
        chk("R4", "freq_ok one edge before first result", int'(freq_ok), 0);
        @(negedge ref_clk);
        chk("R4", "freq_ok at first result", int'(freq_ok), 1);
    endtask

    initial begin
        m_dirty = 0;
        repeat (4) @(negedge ref_clk);
        chk("R1", "freq_ok in reset", int'(freq_ok), 0);
        chk("R1", "track_ref in reset", int'(track_ref), 1);
        rst = 1'b0;
        @(negedge ref_clk);
        chk("R1", "freq_ok after reset", int'(freq_ok), 0);
        repeat (20) @(negedge ref_clk);
        chk("R2", "track_ref while forced", int'(track_ref), 1);

        // nominal frequency: R3, R4
        release_and_lock();
        wait_windows(2);
        chk("R5", "freq_ok steady at nominal", int'(freq_ok), 1);

        // offset above threshold: R7
        set_period(256);
        wait_windows(3);
        chk("R7", "freq_ok after slow drift", int'(freq_ok), 0);

        // fast offset outside, then inside tolerance: R6
        set_period(244);
        wait_windows(3);
        chk("R6", "freq_ok fast outside", int'(freq_ok), 0);
        set_period(247);
        wait_windows(3);
        chk("R6", "freq_ok fast inside", int'(freq_ok), 1);
        set_period(252);
        wait_windows(3);
        chk("R6", "freq_ok slow inside", int'(freq_ok), 1);
        set_period(250);
        wait_windows(3);

        // override mid-measurement: R2
        force_ref_n = 1'b0;
        repeat (2) @(negedge ref_clk);
        chk("R2", "freq_ok two edges after override", int'(freq_ok), 1);
        @(negedge ref_clk);
        chk("R2", "freq_ok three edges after override", int'(freq_ok), 0);
        chk("R2", "track_ref three edges after override", int'(track_ref), 1);
        repeat (10) @(negedge ref_clk);
        release_and_lock();

        // override lands on a window-closing edge: R8
        while (!(m_st == 2 && m_cnt == WIN - 3)) @(negedge ref_clk);
        force_ref_n = 1'b0;
        repeat (2) @(negedge ref_clk);
        chk("R8", "freq_ok before collision edge", int'(freq_ok), 1);
        @(negedge ref_clk);
        chk("R8", "freq_ok on collision edge", int'(freq_ok), 0);
        chk("R8", "track_ref on collision edge", int'(track_ref), 1);
        repeat (5) @(negedge ref_clk);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge ref_clk);
        errors++;
        checks++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule